// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block produces the fetch address for a small vector shader core. Each cycle it looks at the decoded instruction held at its current address and moves the program counter. The instruction arrives as opcode, target address, instruction count, condition reference bits, combine mode and boolean-uniform select. Arithmetic work is done elsewhere, and the sequencer simply steps past it. Jumps, subroutine calls, if/else regions and counted loops are all handled, and an end instruction stops the program.

Calls, both arms of an if, and loops all push the same kind of frame onto one small stack. A frame holds a stop address, a resume address, a rewind address, a repeat count and a loop step. Before any instruction is executed, the sequencer compares the counter against the stop address of the top frame. When they match, it spends that cycle adding the step to the loop register, and then either rewinds the frame or pops it. The counter, the loop register and the stack live inside the block. Program memory and uniform storage sit outside and are seen only through input ports.

Top module: `flow_seq`

## Requirements
- R1: After reset the block is idle: pc_o=0, busy_o=0, done_o=0, ovf_o=0, al_o=0. A start_i pulse makes the next cycle show pc_o=entry_i, busy_o=1, done_o=0, ovf_o=0, al_o=0 and an empty stack.
- R2: The opcode encodings are 0 NOP, 1 END, 2 JMPC, 3 JMPU, 4 CALL, 5 CALLC, 6 CALLU, 7 IFU, 8 IFC and 9 LOOP. Any other value is an ordinary instruction. NOP and ordinary instructions advance pc_o by one, wrapping modulo 2^PC_W.
- R3: For JMPC, CALLC and IFC the condition is built from two terms, a=(ref_x_i==flags_i[0]) and b=(ref_y_i==flags_i[1]). cmb_i selects how they combine: 0 gives a|b, 1 gives a&b, 2 gives a alone and 3 gives b alone. JMPU, CALLU and IFU instead use bool_i[bsel_i].
- R4: JMPC and JMPU load pc_o with dst_i when their condition is true, and otherwise advance by one.
- R5: CALL pushes a frame with stop=dst+cnt, resume=pc+1, rewind=dst, repeat=0 and step=0, then moves to dst. When the counter reaches dst+cnt, execution resumes at pc+1.
- R6: CALLC and CALLU perform a CALL only when their condition holds. Otherwise they advance by one.
- R7: When its condition is true, IFU/IFC runs pc+1 up to dst-1. When it is false, it runs dst up to dst+cnt-1. Both arms continue at dst+cnt.
- R8: LOOP sets al_o=base_i and runs the body pc+1..dst a total of rep_i+1 times. At the end of every pass step_i is added to al_o, and execution then continues at dst+1.
- R9: A cycle in which pc_o equals the top frame's stop address executes nothing (exec_o=0). In that cycle the loop register gains the frame's step, and the counter moves to the rewind address, or to the resume address when the repeat count was zero, in which case the frame is popped.
- R10: Executing END sets done_o=1 and busy_o=0 on the next cycle, and pc_o then holds. While idle, exec_o stays 0.
- R11: A push attempted while DEPTH frames are stacked is dropped. The instruction then only advances pc_o by one, and ovf_o rises and stays high until the next start.
- R12: Frames that share one stop address are unwound one per cycle, innermost first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin execution at entry_i |
| entry_i | input | PC_W | Entry address |
| op_i | input | 4 | Opcode of instruction at pc_o |
| dst_i | input | PC_W | Target address field |
| cnt_i | input | PC_W | Instruction count field |
| ref_x_i | input | 1 | Reference bit for flag 0 |
| ref_y_i | input | 1 | Reference bit for flag 1 |
| cmb_i | input | 2 | Condition combine mode |
| flags_i | input | 2 | Condition flags from the arithmetic unit |
| bsel_i | input | BS_W | Boolean uniform select |
| bool_i | input | BOOL_N | Boolean uniform bits |
| rep_i | input | LW | Loop repeat count (integer uniform x) |
| base_i | input | LW | Loop register initial value (integer uniform y) |
| step_i | input | LW | Loop register step (integer uniform z) |
| pc_o | output | PC_W | Fetch address |
| exec_o | output | 1 | Instruction at pc_o is executed this cycle |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | END executed |
| ovf_o | output | 1 | Sticky stack overflow |
| al_o | output | LW | Loop address register |

## Verification
The hardest case to reach is a run of frames that all end on the same address while the stack is nearly full, because the ports reach it only through a particular nesting of calls, ifs and loops. The stimulus builds that nesting with directed programs: calls five deep to force an overflow, and an if region nested inside a call with both ending on one address. Random programs, each restarted after a bounded run, add odd combinations. A cycle-stepped bench model follows every fetch address, so any difference in unwinding order appears at the cycle where it happens.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int PC_W = 6;
    localparam int LW   = 8;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_END   = 4'd1,
        OP_JMPC  = 4'd2,
        OP_JMPU  = 4'd3,
        OP_CALL  = 4'd4,
        OP_CALLC = 4'd5,
        OP_CALLU = 4'd6,
        OP_IFU   = 4'd7,
        OP_IFC   = 4'd8,
        OP_LOOP  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        CMB_OR  = 2'd0,
        CMB_AND = 2'd1,
        CMB_X   = 2'd2,
        CMB_Y   = 2'd3
    } cmb_e;

    typedef struct packed {
        logic [PC_W-1:0] stop_a;
        logic [PC_W-1:0] back_a;
        logic [PC_W-1:0] top_a;
        logic [LW-1:0]   reps;
        logic [LW-1:0]   step;
    } frame_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            busy;
        logic            done;
        logic            ovf;
        logic [LW-1:0]   al;
    } run_t;
endpackage

// File: rtl/fs_cond.sv
module fs_cond
    import flow_pkg::*;
#(
    parameter int BOOL_N = 16,
    localparam int BS_W = (BOOL_N > 1) ? $clog2(BOOL_N) : 1
) (
    input  logic              use_bool_i,
    input  logic [BOOL_N-1:0] bool_i,
    input  logic [BS_W-1:0]   bsel_i,
    input  logic              ref_x_i,
    input  logic              ref_y_i,
    input  logic [1:0]        cmb_i,
    input  logic [1:0]        flags_i,
    output logic              take_o
);
    logic match_x, match_y, flag_take;

    always_comb begin
        match_x = (ref_x_i == flags_i[0]);
        match_y = (ref_y_i == flags_i[1]);
        case (cmb_e'(cmb_i))
            CMB_OR:  flag_take = match_x | match_y;
            CMB_AND: flag_take = match_x & match_y;
            CMB_X:   flag_take = match_x;
            default: flag_take = match_y;
        endcase
        take_o = use_bool_i ? bool_i[bsel_i] : flag_take;
    end
endmodule

// File: rtl/fs_stack.sv
module fs_stack
    import flow_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr_i,
    input  logic   push_i,
    input  frame_t push_f_i,
    input  logic   pop_i,
    input  logic   dec_i,
    output frame_t top_o,
    output logic   empty_o,
    output logic   full_o
);
    frame_t mem_q [DEPTH];
    frame_t mem_d [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] wr_idx, top_idx;
    logic [CNT_W-1:0] top_cnt;

    always_comb begin
        top_cnt = cnt_q - 1'b1;
        wr_idx  = cnt_q[IDX_W-1:0];
        top_idx = top_cnt[IDX_W-1:0];
        empty_o = (cnt_q == '0);
        full_o  = (cnt_q == CNT_W'(DEPTH));
        top_o   = mem_q[top_idx];
    end

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (push_i && !full_o) begin
            mem_d[wr_idx] = push_f_i;
            cnt_d = cnt_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            cnt_d = top_cnt;
        end else if (dec_i && !empty_o) begin
            mem_d[top_idx].reps = mem_q[top_idx].reps - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import flow_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int BOOL_N = 16,
    localparam int BS_W = (BOOL_N > 1) ? $clog2(BOOL_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PC_W-1:0]   entry_i,
    input  logic [3:0]        op_i,
    input  logic [PC_W-1:0]   dst_i,
    input  logic [PC_W-1:0]   cnt_i,
    input  logic              ref_x_i,
    input  logic              ref_y_i,
    input  logic [1:0]        cmb_i,
    input  logic [1:0]        flags_i,
    input  logic [BS_W-1:0]   bsel_i,
    input  logic [BOOL_N-1:0] bool_i,
    input  logic [LW-1:0]     rep_i,
    input  logic [LW-1:0]     base_i,
    input  logic [LW-1:0]     step_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              exec_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic [LW-1:0]     al_o
);
    run_t   st_q, st_d;
    frame_t s_top, push_f;
    logic   s_empty, s_full;
    logic   s_push, s_pop, s_dec, s_clr;
    logic   use_bool, take, hit, want;
    logic [PC_W-1:0] pc_inc, dst_end, dst_nxt;
    op_e    op;

    assign op       = op_e'(op_i);
    assign use_bool = (op == OP_JMPU) || (op == OP_CALLU) || (op == OP_IFU);

    fs_cond #(.BOOL_N(BOOL_N)) u_cond (
        .use_bool_i(use_bool),
        .bool_i    (bool_i),
        .bsel_i    (bsel_i),
        .ref_x_i   (ref_x_i),
        .ref_y_i   (ref_y_i),
        .cmb_i     (cmb_i),
        .flags_i   (flags_i),
        .take_o    (take)
    );

    fs_stack #(.DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (s_clr),
        .push_i  (s_push),
        .push_f_i(push_f),
        .pop_i   (s_pop),
        .dec_i   (s_dec),
        .top_o   (s_top),
        .empty_o (s_empty),
        .full_o  (s_full)
    );

    always_comb begin
        st_d    = st_q;
        s_push  = 1'b0;
        s_pop   = 1'b0;
        s_dec   = 1'b0;
        s_clr   = 1'b0;
        want    = 1'b0;
        push_f  = '0;
        pc_inc  = st_q.pc + 1'b1;
        dst_end = dst_i + cnt_i;
        dst_nxt = dst_i + 1'b1;
        hit     = st_q.busy && !s_empty && (st_q.pc == s_top.stop_a);

        if (start_i) begin
            st_d.pc   = entry_i;
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.ovf  = 1'b0;
            st_d.al   = '0;
            s_clr     = 1'b1;
        end else if (hit) begin
            st_d.al = st_q.al + s_top.step;
            if (s_top.reps == '0) begin
                s_pop   = 1'b1;
                st_d.pc = s_top.back_a;
            end else begin
                s_dec   = 1'b1;
                st_d.pc = s_top.top_a;
            end
        end else if (st_q.busy) begin
            st_d.pc = pc_inc;
            case (op)
                OP_END: begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.pc   = st_q.pc;
                end
                OP_JMPC, OP_JMPU: begin
                    if (take) st_d.pc = dst_i;
                end
                OP_CALL, OP_CALLC, OP_CALLU: begin
                    if (op == OP_CALL || take) begin
                        want    = 1'b1;
                        push_f  = '{stop_a: dst_end, back_a: pc_inc, top_a: dst_i,
                                    reps: '0, step: '0};
                        st_d.pc = dst_i;
                    end
                end
                OP_IFU, OP_IFC: begin
                    want = 1'b1;
                    if (take) begin
                        push_f = '{stop_a: dst_i, back_a: dst_end, top_a: pc_inc,
                                   reps: '0, step: '0};
                    end else begin
                        push_f  = '{stop_a: dst_end, back_a: dst_end, top_a: dst_i,
                                    reps: '0, step: '0};
                        st_d.pc = dst_i;
                    end
                end
                OP_LOOP: begin
                    want    = 1'b1;
                    push_f  = '{stop_a: dst_nxt, back_a: dst_nxt, top_a: pc_inc,
                                reps: rep_i, step: step_i};
                    st_d.al = base_i;
                end
                default: ;
            endcase
            if (want) begin
                if (s_full) begin
                    st_d.ovf = 1'b1;
                    st_d.pc  = pc_inc;
                    st_d.al  = st_q.al;
                end else begin
                    s_push = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o   = st_q.pc;
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign ovf_o  = st_q.ovf;
    assign al_o   = st_q.al;
    assign exec_o = st_q.busy && !hit;
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk
    import flow_pkg::*;
#(
    parameter int BOOL_N = 16,
    localparam int BS_W = (BOOL_N > 1) ? $clog2(BOOL_N) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [PC_W-1:0]   entry_i,
    input logic [3:0]        op_i,
    input logic [PC_W-1:0]   dst_i,
    input logic [BS_W-1:0]   bsel_i,
    input logic [BOOL_N-1:0] bool_i,
    input logic [PC_W-1:0]   pc_o,
    input logic              exec_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              ovf_o
);
    // R1
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (pc_o == $past(entry_i)) && busy_o && !done_o && !ovf_o);

    // R2
    nop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op_i == OP_NOP && !start_i) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

    // R4
    jmpu_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op_i == OP_JMPU && bool_i[bsel_i] && !start_i) |=> (pc_o == $past(dst_i)));

    // R10
    end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op_i == OP_END && !start_i) |=> (done_o && !busy_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !exec_o);

    // R10
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !start_i) |=> ovf_o);
endmodule

bind flow_seq flow_seq_chk #(.BOOL_N(BOOL_N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .entry_i(entry_i),
    .op_i   (op_i),
    .dst_i  (dst_i),
    .bsel_i (bsel_i),
    .bool_i (bool_i),
    .pc_o   (pc_o),
    .exec_o (exec_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .ovf_o  (ovf_o)
);

// File: tb/sim_flow_seq.sv
module sim_flow_seq;
    import flow_pkg::*;

    localparam int MD   = 4;
    localparam int NADR = 1 << PC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            start_i = 1'b0;
    logic [PC_W-1:0] entry_i = '0;
    logic [1:0]      flags_i = '0;
    logic [15:0]     bool_i  = '0;
    logic [LW-1:0]   rep_i = '0, base_i = '0, step_i = '0;
    logic [3:0]      op_i;
    logic [PC_W-1:0] dst_i, cnt_i;
    logic            ref_x_i, ref_y_i;
    logic [1:0]      cmb_i;
    logic [3:0]      bsel_i;
    logic [PC_W-1:0] pc_o;
    logic            exec_o, busy_o, done_o, ovf_o;
    logic [LW-1:0]   al_o;

    logic [3:0]      p_op  [NADR];
    logic [PC_W-1:0] p_dst [NADR];
    logic [PC_W-1:0] p_cnt [NADR];
    logic            p_rx  [NADR];
    logic            p_ry  [NADR];
    logic [1:0]      p_md  [NADR];
    logic [3:0]      p_bs  [NADR];

    assign op_i    = p_op[pc_o];
    assign dst_i   = p_dst[pc_o];
    assign cnt_i   = p_cnt[pc_o];
    assign ref_x_i = p_rx[pc_o];
    assign ref_y_i = p_ry[pc_o];
    assign cmb_i   = p_md[pc_o];
    assign bsel_i  = p_bs[pc_o];

    flow_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .entry_i(entry_i),
        .op_i(op_i), .dst_i(dst_i), .cnt_i(cnt_i), .ref_x_i(ref_x_i),
        .ref_y_i(ref_y_i), .cmb_i(cmb_i), .flags_i(flags_i), .bsel_i(bsel_i),
        .bool_i(bool_i), .rep_i(rep_i), .base_i(base_i), .step_i(step_i),
        .pc_o(pc_o), .exec_o(exec_o), .busy_o(busy_o), .done_o(done_o),
        .ovf_o(ovf_o), .al_o(al_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit fixed_flags = 1'b0;

    // bench model state
    logic [PC_W-1:0] m_pc = '0;
    logic            m_busy = 0, m_done = 0, m_ovf = 0;
    logic [LW-1:0]   m_al = '0;
    int              m_sp = 0;
    logic [PC_W-1:0] ms_stop [MD];
    logic [PC_W-1:0] ms_back [MD];
    logic [PC_W-1:0] ms_top  [MD];
    logic [LW-1:0]   ms_rep  [MD];
    logic [LW-1:0]   ms_inc  [MD];
    string           m_tag = "R1";

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic bit cond_of(logic rx, logic ry, logic [1:0] md, logic [1:0] fl);
        bit a = (rx == fl[0]);
        bit b = (ry == fl[1]);
        case (md)
            2'd0: return a | b;
            2'd1: return a & b;
            2'd2: return a;
            default: return b;
        endcase
    endfunction

    function automatic bit m_hit();
        return m_busy && m_sp > 0 && m_pc == ms_stop[m_sp-1];
    endfunction

    task automatic chk(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        bit ex = m_hit() ? 1'b0 : m_busy;
        checks++;
        if (pc_o !== m_pc || busy_o !== m_busy || done_o !== m_done || ovf_o !== m_ovf ||
            al_o !== m_al || exec_o !== ex) begin
            fails++;
            $display("FAIL %s: actual pc=%0d busy=%0b exec=%0b done=%0b ovf=%0b al=%0d expected pc=%0d busy=%0b exec=%0b done=%0b ovf=%0b al=%0d",
                     m_tag, pc_o, busy_o, exec_o, done_o, ovf_o, al_o,
                     m_pc, m_busy, ex, m_done, m_ovf, m_al);
        end
    endtask

    task automatic m_push(logic [PC_W-1:0] s, logic [PC_W-1:0] b, logic [PC_W-1:0] t,
                          logic [LW-1:0] r, logic [LW-1:0] i, output bit ok);
        if (m_sp == MD) begin
            m_ovf = 1'b1;
            ok = 1'b0;
        end else begin
            ms_stop[m_sp] = s; ms_back[m_sp] = b; ms_top[m_sp] = t;
            ms_rep[m_sp] = r;  ms_inc[m_sp] = i;
            m_sp++;
            ok = 1'b1;
        end
    endtask

    task automatic m_step();
        logic [PC_W-1:0] d, c, nx, de;
        bit t, ok;
        logic [3:0] o;
        if (start_i) begin
            m_pc = entry_i; m_busy = 1; m_done = 0; m_ovf = 0; m_al = '0; m_sp = 0;
            m_tag = "R1";
            return;
        end
        if (!m_busy) begin m_tag = "R10"; return; end
        if (m_hit()) begin
            m_al = m_al + ms_inc[m_sp-1];
            if (ms_rep[m_sp-1] == 0) begin
                m_pc = ms_back[m_sp-1];
                m_sp--;
                m_tag = (m_sp > 0 && m_pc == ms_stop[m_sp-1]) ? "R12" : "R9";
            end else begin
                ms_rep[m_sp-1] = ms_rep[m_sp-1] - 1'b1;
                m_pc = ms_top[m_sp-1];
                m_tag = "R8";
            end
            return;
        end
        o  = p_op[m_pc];
        d  = p_dst[m_pc];
        c  = p_cnt[m_pc];
        nx = m_pc + 1'b1;
        de = d + c;
        t  = (o == 4'd3 || o == 4'd6 || o == 4'd7) ? bool_i[p_bs[m_pc]]
                                                   : cond_of(p_rx[m_pc], p_ry[m_pc], p_md[m_pc], flags_i);
        case (o)
            4'd1: begin m_busy = 0; m_done = 1; m_tag = "R10"; end
            4'd2, 4'd3: begin m_pc = t ? d : nx; m_tag = (o == 4'd2) ? "R3" : "R4"; end
            4'd4, 4'd5, 4'd6: begin
                m_tag = (o == 4'd4) ? "R5" : "R6";
                if (o == 4'd4 || t) begin
                    m_push(de, nx, d, '0, '0, ok);
                    m_pc = ok ? d : nx;
                    if (!ok) m_tag = "R11";
                end else m_pc = nx;
            end
            4'd7, 4'd8: begin
                m_tag = "R7";
                if (t) begin m_push(d, de, nx, '0, '0, ok); m_pc = nx; end
                else begin m_push(de, de, d, '0, '0, ok); m_pc = ok ? d : nx; end
                if (!ok) m_tag = "R11";
            end
            4'd9: begin
                m_tag = "R8";
                m_push(d + 1'b1, d + 1'b1, nx, rep_i, step_i, ok);
                if (ok) m_al = base_i; else m_tag = "R11";
                m_pc = nx;
            end
            default: begin m_pc = nx; m_tag = "R2"; end
        endcase
    endtask

    task automatic tick(bit s);
        @(negedge clk);
        cmp_model();
        start_i = s;
        if (!fixed_flags) flags_i = 2'($urandom);
        m_step();
    endtask

    task automatic clear_prog();
        for (int a = 0; a < NADR; a++) begin
            p_op[a] = 4'd0; p_dst[a] = '0; p_cnt[a] = '0;
            p_rx[a] = 0; p_ry[a] = 0; p_md[a] = '0; p_bs[a] = '0;
        end
    endtask

    task automatic run_prog(int limit);
        tick(1'b1);
        for (int k = 0; k < limit; k++) begin
            tick(1'b0);
            if (!m_busy && m_done) begin
                tick(1'b0);
                break;
            end
        end
    endtask

    initial begin
        bit seen1;
        void'($urandom(32'd4242));
        clear_prog();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 reset pc", pc_o == 0, pc_o, 0);
        chk("R1 reset idle", {busy_o, done_o, ovf_o, exec_o} == 4'b0, {busy_o, done_o, ovf_o, exec_o}, 0);

        // R8: loop x=2 y=5 z=3 -> al = 5 + 3*3
        clear_prog();
        p_op[0] = 4'd9; p_dst[0] = 6'd2; p_op[3] = 4'd1;
        rep_i = 8'd2; base_i = 8'd5; step_i = 8'd3;
        run_prog(100);
        chk("R8 loop register", al_o == 8'd14, al_o, 14);
        chk("R10 done after loop", done_o && !busy_o, done_o, 1);

        // R5: call returns to pc+1
        clear_prog();
        p_op[0] = 4'd4; p_dst[0] = 6'd8; p_cnt[0] = 6'd2; p_op[1] = 4'd1;
        run_prog(100);
        chk("R5 call return", pc_o == 1 && done_o, pc_o, 1);

        // R7: if on true and false arms
        for (int arm = 0; arm < 2; arm++) begin
            clear_prog();
            p_op[0] = 4'd7; p_dst[0] = 6'd3; p_cnt[0] = 6'd2; p_bs[0] = 4'd5;
            p_op[5] = 4'd1;
            bool_i = (arm == 0) ? 16'h0020 : 16'h0000;
            seen1 = 0;
            tick(1'b1);
            for (int k = 0; k < 40 && !(m_done && !m_busy); k++) begin
                tick(1'b0);
                if (pc_o == 1 && exec_o) seen1 = 1;
            end
            tick(1'b0);
            chk("R7 arm choice", seen1 == (arm == 0), seen1, arm == 0);
            chk("R7 join address", pc_o == 5, pc_o, 5);
        end

        // R11: five nested calls overflow a 4-deep stack
        clear_prog();
        for (int a = 0; a < 5; a++) begin
            p_op[a] = 4'd4; p_dst[a] = 6'(a + 1); p_cnt[a] = 6'd20;
        end
        p_op[5] = 4'd1;
        run_prog(100);
        chk("R11 overflow flag", ovf_o == 1'b1, ovf_o, 1);
        chk("R11 dropped push advances", pc_o == 5, pc_o, 5);

        // R12: if frame and call frame share stop address 8
        clear_prog();
        p_op[0] = 4'd4; p_dst[0] = 6'd4; p_cnt[0] = 6'd4; p_op[1] = 4'd1;
        p_op[4] = 4'd7; p_dst[4] = 6'd8; p_cnt[4] = 6'd0; p_bs[4] = 4'd0;
        bool_i = 16'h0001;
        run_prog(100);
        chk("R12 stacked unwind", pc_o == 1 && done_o, pc_o, 1);

        // R3: each combine mode under fixed flags
        fixed_flags = 1'b1;
        for (int md = 0; md < 4; md++) begin
            for (int fl = 0; fl < 4; fl++) begin
                bit exp;
                clear_prog();
                p_op[0] = 4'd2; p_dst[0] = 6'd10; p_md[0] = 2'(md);
                p_rx[0] = 1'b1; p_ry[0] = 1'b0;
                p_op[1] = 4'd1; p_op[10] = 4'd1;
                flags_i = 2'(fl);
                exp = cond_of(1'b1, 1'b0, 2'(md), 2'(fl));
                run_prog(20);
                chk("R3 combine mode", pc_o == (exp ? 10 : 1), pc_o, exp ? 10 : 1);
            end
        end
        fixed_flags = 1'b0;

        // R2 R4 R6 R9: random programs against the bench model
        for (int r = 0; r < 40; r++) begin
            for (int a = 0; a < NADR; a++) begin
                int w = $urandom % 14;
                p_op[a]  = (w >= 12) ? 4'd0 : 4'(w);
                if (w == 1 && ($urandom % 3) != 0) p_op[a] = 4'd11;
                p_dst[a] = PC_W'($urandom);
                p_cnt[a] = PC_W'($urandom % 6);
                p_rx[a]  = 1'($urandom); p_ry[a] = 1'($urandom);
                p_md[a]  = 2'($urandom); p_bs[a] = 4'($urandom);
            end
            bool_i = 16'($urandom);
            rep_i  = 8'($urandom % 3);
            base_i = 8'($urandom);
            step_i = 8'($urandom);
            entry_i = PC_W'($urandom);
            run_prog(200);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule